// File: doc/BRIEF.md
# Test Command Sequence Decoder

This block sits behind a serial control port and watches the bytes that port delivers. Most bytes are ordinary traffic. Two fixed eight-byte patterns are commands that start built-in tests, and the block raises a one-cycle start strobe when it sees either one. Each pattern is four leading key bytes followed by four zero bytes.

The register-probe pattern carries a selector byte in its fourth position. When the pattern completes, the block reads the control register that the selector names and writes the value into a holding register, where software can read it back. The control register file sits outside the block and is reached through a combinational read port. Two of its indices are the block's own holding registers, and the block serves those itself. If the probe targets holding register 0, the result is written to holding register 1 so that the value being read is not overwritten.

The memory self-test pattern only pulses a start strobe toward the test engine. Bytes are consumed only in cycles where the valid strobe is high.

Top module: `test_cmd_decoder`

## Requirements
- R1: After reset, holdData0 and holdData1 are zero and regTestPulse and memTestStart are low.
- R2: The valid bytes 0x53, 0x70, 0xEE, n, 0x00, 0x00, 0x00, 0x00, accepted on consecutive valid strobes, produce a one-cycle high on regTestPulse. The pulse appears in the cycle after the clock edge that accepts the final byte. Any value of n is accepted.
- R3: When that pattern completes with n in the range INDEX_BASE (48) to INDEX_BASE+NUM_REGS-1, the register at index n-48 is copied into holdData0, which shows the new value in the same cycle as regTestPulse. Index HOLD1_IDX (9) reads holdData1. Index HOLD0_IDX (8) reads holdData0. Every other index reads cfgRdData at address cfgRdAddr = n-48.
- R4: When n-48 equals HOLD0_IDX, the value of holdData0 is written into holdData1 instead, and holdData0 keeps its value.
- R5: The valid bytes 0x4D, 0xEA, 0x6D, 0x54, 0x00, 0x00, 0x00, 0x00 produce a one-cycle high on memTestStart in the cycle after the final byte is accepted. This pattern leaves both holding registers unchanged.
- R6: A valid byte that differs from the next expected byte of a pattern restarts that pattern's matching. That same byte then counts as the first byte of a new attempt if it equals the pattern's first byte (0x53 or 0x4D).
- R7: After a pattern completes, matching starts over from its first byte. Each start strobe is high for exactly one cycle per completed pattern, and patterns sent back to back each produce their own strobe.
- R8: A completed register-probe pattern whose n is below 48, or at or above 48+NUM_REGS, still pulses regTestPulse but changes neither holding register.
- R9: Cycles with byteValid low are ignored, whatever value byteData holds. A pattern may be spread across such gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | High when byteData carries a received byte |
| byteData | input | 8 | Received byte |
| cfgRdAddr | output | AW | Read address into the control register file (n-48, truncated) |
| cfgRdData | input | DATA_W | Combinational read data for cfgRdAddr |
| holdData0 | output | DATA_W | Holding data register 0 |
| holdData1 | output | DATA_W | Holding data register 1 |
| regTestPulse | output | 1 | One-cycle strobe: register-probe pattern completed |
| memTestStart | output | 1 | One-cycle strobe: memory-test pattern completed |

## Verification
The bench builds the block with NUM_REGS = 16, INDEX_BASE = 48, and the holding registers at indices 8 and 9. With these values, selector 0x40 is the first index past the end of the file, selector 0x2F is just below the base, and selectors 0x38 and 0x39 reach the two holding registers through the internal read path. The external register file uses distinct junk values at those two indices, so a design that reads them from outside gives a visibly wrong result. The stimulus includes doubled first bytes, mismatches at the last byte, gaps with pattern-like data while byteValid is low, and a long mixed stream. Overlapping attempts and the restart rule are checked on every cycle against the reference model.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  // Command strobes raised by the control side for one cycle
  typedef struct packed {
    logic copyReq;   // register-probe pattern completed
    logic memStart;  // memory-test pattern completed
  } ctlStrobe_t;

  localparam int unsigned PAT_LEN = 8;
endpackage

// File: rtl/tcd_matcher.sv
module tcd_matcher #(
  parameter int unsigned         LEN     = 8,
  parameter logic [8*LEN-1:0]    PATTERN = '0,
  parameter logic [LEN-1:0]      WILD    = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic       complete,
  output logic [7:0] capByte
);
  localparam int unsigned PW = $clog2(LEN);
  localparam logic [7:0] FIRST = PATTERN[8*LEN-1 -: 8];

  logic [PW-1:0] ptrQ;
  logic [7:0]    expByte;
  logic          accept;
  logic          wildHit;

  always_comb begin
    expByte  = PATTERN[8*(LEN-1-int'(ptrQ)) +: 8];
    wildHit  = WILD[ptrQ];
    accept   = byteValid && (wildHit || (byteData == expByte));
    complete = accept && (ptrQ == PW'(LEN-1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ    <= '0;
      capByte <= '0;
    end else if (byteValid) begin
      if (accept && wildHit) capByte <= byteData;
      if (complete)                ptrQ <= '0;
      else if (accept)             ptrQ <= ptrQ + PW'(1);
      else if (byteData == FIRST)  ptrQ <= PW'(1);
      else                         ptrQ <= '0;
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> $stable(ptrQ));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (ptrQ == '0));
endmodule

// File: rtl/tcd_ctrl.sv
module tcd_ctrl
  import tcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output ctlStrobe_t strobe,
  output logic [7:0] selByte
);
  localparam int unsigned NPAT    = 2;
  localparam int unsigned REG_PAT = 0;
  localparam int unsigned MEM_PAT = 1;

  localparam logic [8*PAT_LEN-1:0] PATS [NPAT] = '{
    64'h5370_EE00_0000_0000,
    64'h4DEA_6D54_0000_0000
  };
  // bit i marks byte i (first byte = bit 0) as "any value"
  localparam logic [PAT_LEN-1:0] WILDS [NPAT] = '{8'b0000_1000, 8'b0000_0000};

  logic       doneArr [NPAT];
  logic [7:0] capArr  [NPAT];

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    tcd_matcher #(
      .LEN    (PAT_LEN),
      .PATTERN(PATS[g]),
      .WILD   (WILDS[g])
    ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .byteValid(byteValid),
      .byteData (byteData),
      .complete (doneArr[g]),
      .capByte  (capArr[g])
    );
  end

  always_comb begin
    strobe.copyReq  = doneArr[REG_PAT];
    strobe.memStart = doneArr[MEM_PAT];
    selByte         = capArr[REG_PAT];
  end

  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.copyReq && strobe.memStart));
endmodule

// File: rtl/tcd_datapath.sv
module tcd_datapath
  import tcd_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_REGS   = 16,
  parameter int unsigned INDEX_BASE = 48,
  parameter int unsigned HOLD0_IDX  = 8,
  parameter int unsigned HOLD1_IDX  = 9,
  parameter int unsigned AW         = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        selByte,
  output logic [AW-1:0]     cfgRdAddr,
  input  logic [DATA_W-1:0] cfgRdData,
  output logic [DATA_W-1:0] holdData0,
  output logic [DATA_W-1:0] holdData1,
  output logic              regTestPulse,
  output logic              memTestStart
);
  logic [8:0]        offset;
  logic              idxValid;
  logic              srcIsHold0;
  logic              srcIsHold1;
  logic [DATA_W-1:0] srcData;
  logic [DATA_W-1:0] hold0Q, hold1Q;

  always_comb begin
    offset     = {1'b0, selByte} - 9'(INDEX_BASE);
    idxValid   = !offset[8] && (offset < 9'(NUM_REGS));
    srcIsHold0 = (offset == 9'(HOLD0_IDX));
    srcIsHold1 = (offset == 9'(HOLD1_IDX));
    cfgRdAddr  = offset[AW-1:0];
    if (srcIsHold0)      srcData = hold0Q;
    else if (srcIsHold1) srcData = hold1Q;
    else                 srcData = cfgRdData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold0Q       <= '0;
      hold1Q       <= '0;
      regTestPulse <= 1'b0;
      memTestStart <= 1'b0;
    end else begin
      regTestPulse <= strobe.copyReq;
      memTestStart <= strobe.memStart;
      if (strobe.copyReq && idxValid) begin
        if (srcIsHold0) hold1Q <= srcData;
        else            hold0Q <= srcData;
      end
    end
  end

  assign holdData0 = hold0Q;
  assign holdData1 = hold1Q;

  // R7
  reg_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regTestPulse |=> !regTestPulse);

  // R7
  mem_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memTestStart |=> !memTestStart);

  // R8
  no_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.copyReq && !idxValid) |=> ($stable(hold0Q) && $stable(hold1Q)));

  // R4
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.copyReq && idxValid && srcIsHold0) |=>
      ((hold1Q == $past(hold0Q)) && $stable(hold0Q)));

  // R5
  mem_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.memStart |=> ($stable(hold0Q) && $stable(hold1Q)));
endmodule

// File: rtl/test_cmd_decoder.sv
module test_cmd_decoder
  import tcd_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NUM_REGS   = 16,
  parameter int unsigned INDEX_BASE = 48,
  parameter int unsigned HOLD0_IDX  = 8,
  parameter int unsigned HOLD1_IDX  = 9,
  localparam int unsigned AW        = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic [AW-1:0]     cfgRdAddr,
  input  logic [DATA_W-1:0] cfgRdData,
  output logic [DATA_W-1:0] holdData0,
  output logic [DATA_W-1:0] holdData1,
  output logic              regTestPulse,
  output logic              memTestStart
);
  ctlStrobe_t ctlStrobe;
  logic [7:0] selByte;

  tcd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .byteValid(byteValid),
    .byteData (byteData),
    .strobe   (ctlStrobe),
    .selByte  (selByte)
  );

  tcd_datapath #(
    .DATA_W    (DATA_W),
    .NUM_REGS  (NUM_REGS),
    .INDEX_BASE(INDEX_BASE),
    .HOLD0_IDX (HOLD0_IDX),
    .HOLD1_IDX (HOLD1_IDX),
    .AW        (AW)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (ctlStrobe),
    .selByte     (selByte),
    .cfgRdAddr   (cfgRdAddr),
    .cfgRdData   (cfgRdData),
    .holdData0   (holdData0),
    .holdData1   (holdData1),
    .regTestPulse(regTestPulse),
    .memTestStart(memTestStart)
  );
endmodule

// File: tb/test_cmd_decoder_tb.sv
module test_cmd_decoder_tb;
  localparam int DATA_W     = 16;
  localparam int NUM_REGS   = 16;
  localparam int INDEX_BASE = 48;
  localparam int HOLD0_IDX  = 8;
  localparam int HOLD1_IDX  = 9;
  localparam int AW         = $clog2(NUM_REGS);

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic              rst_n;
  logic              byteValid;
  logic [7:0]        byteData;
  logic [AW-1:0]     cfgRdAddr;
  logic [DATA_W-1:0] cfgRdData;
  logic [DATA_W-1:0] holdData0, holdData1;
  logic              regTestPulse, memTestStart;

  logic [DATA_W-1:0] regFile [NUM_REGS];
  assign cfgRdData = regFile[cfgRdAddr];

  test_cmd_decoder #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .INDEX_BASE(INDEX_BASE),
    .HOLD0_IDX(HOLD0_IDX), .HOLD1_IDX(HOLD1_IDX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData),
    .holdData0(holdData0), .holdData1(holdData1),
    .regTestPulse(regTestPulse), .memTestStart(memTestStart)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R1";
  bit    finished = 1'b0;

  // reference model state
  byte unsigned regPat [8] = '{8'h53, 8'h70, 8'hEE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  byte unsigned memPat [8] = '{8'h4D, 8'hEA, 8'h6D, 8'h54, 8'h00, 8'h00, 8'h00, 8'h00};
  int          rp = 0;
  int          mp = 0;
  int          nSave = 0;
  logic [15:0] eH0 = '0, eH1 = '0;
  bit          eReg = 1'b0, eMem = 1'b0;

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    checkEq(phase, "holdData0",    32'(holdData0),    32'(eH0));
    checkEq(phase, "holdData1",    32'(holdData1),    32'(eH1));
    checkEq(phase, "regTestPulse", 32'(regTestPulse), 32'(eReg));
    checkEq(phase, "memTestStart", 32'(memTestStart), 32'(eMem));
  endtask

  task automatic modelStep(input bit v, input byte unsigned b);
    bit          fr = 1'b0;
    bit          fm = 1'b0;
    int          idx;
    logic [15:0] src;
    if (v) begin
      if (rp == 3 || b == regPat[rp]) begin
        if (rp == 3) nSave = b;
        if (rp == 7) begin rp = 0; fr = 1'b1; end else rp++;
      end else rp = (b == regPat[0]) ? 1 : 0;
      if (b == memPat[mp]) begin
        if (mp == 7) begin mp = 0; fm = 1'b1; end else mp++;
      end else mp = (b == memPat[0]) ? 1 : 0;
    end
    eReg = fr;
    eMem = fm;
    if (fr) begin
      idx = nSave - INDEX_BASE;
      if (idx >= 0 && idx < NUM_REGS) begin
        if (idx == HOLD0_IDX)      src = eH0;
        else if (idx == HOLD1_IDX) src = eH1;
        else                       src = regFile[idx];
        if (idx == HOLD0_IDX) eH1 = src; else eH0 = src;
      end
    end
  endtask

  task automatic sendByte(input byte unsigned b);
    @(negedge clk);
    compareAll();
    byteValid = 1'b1;
    byteData  = b;
    modelStep(1'b1, b);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
      byteValid = 1'b0;
      byteData  = 8'($urandom);
      modelStep(1'b0, 8'h00);
    end
  endtask

  task automatic gapData(input byte unsigned b);
    @(negedge clk);
    compareAll();
    byteValid = 1'b0;
    byteData  = b;
    modelStep(1'b0, 8'h00);
  endtask

  task automatic sendReg(input byte unsigned n);
    sendByte(8'h53); sendByte(8'h70); sendByte(8'hEE); sendByte(n);
    for (int i = 0; i < 4; i++) sendByte(8'h00);
  endtask

  task automatic sendMem();
    sendByte(8'h4D); sendByte(8'hEA); sendByte(8'h6D); sendByte(8'h54);
    for (int i = 0; i < 4; i++) sendByte(8'h00);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < NUM_REGS; i++) regFile[i] = 16'hA500 ^ 16'(i * 16'h0413);
    regFile[HOLD0_IDX] = 16'hDEAD;   // must never be used: served internally
    regFile[HOLD1_IDX] = 16'hBEEF;
    rst_n = 1'b0; byteValid = 1'b0; byteData = 8'h00;
    repeat (3) @(negedge clk);
    phase = "R1";
    compareAll();
    rst_n = 1'b1;
    gap(2);

    // R2 / R3: probe index 0 then index 5
    phase = "R3";
    sendReg(8'h30);
    gap(1);
    checkEq("R3", "holdData0 after n=0x30", 32'(holdData0), 32'(regFile[0]));
    phase = "R2";
    sendReg(8'h35);
    gap(1);
    checkEq("R2", "holdData0 after n=0x35", 32'(holdData0), 32'(regFile[5]));

    // R4: probe holding register 0 -> result lands in holding register 1
    phase = "R4";
    sendReg(8'h38);
    gap(1);
    checkEq("R4", "holdData1 redirect", 32'(holdData1), 32'(regFile[5]));
    checkEq("R4", "holdData0 kept",     32'(holdData0), 32'(regFile[5]));
    // R3: probe holding register 1 through the internal path
    phase = "R3";
    sendReg(8'h3A);
    gap(1);
    sendReg(8'h39);
    gap(1);
    checkEq("R3", "holdData0 from holdData1", 32'(holdData0), 32'(regFile[5]));

    // R5: memory test
    phase = "R5";
    sendMem();
    gap(3);

    // R6: doubled first bytes, late mismatch, restart on mismatching byte
    phase = "R6";
    sendByte(8'h53); sendReg(8'h31); gap(1);
    sendByte(8'h4D); sendMem(); gap(1);
    sendByte(8'h53); sendByte(8'h70); sendByte(8'hEE); sendByte(8'h32);
    sendByte(8'h00); sendByte(8'h01); sendByte(8'h00); sendByte(8'h00);
    sendByte(8'h00); sendByte(8'h00); gap(1);
    sendByte(8'h53); sendByte(8'h70); sendByte(8'hEE); sendByte(8'h33);
    sendByte(8'h00); sendByte(8'h00); sendByte(8'h00);
    sendReg(8'h34); gap(1);
    checkEq("R6", "holdData0 after restart", 32'(holdData0), 32'(regFile[4]));
    sendByte(8'h53); sendByte(8'h70); sendByte(8'hEE); sendByte(8'h53);
    sendByte(8'h70); sendByte(8'hEE); sendByte(8'h36);
    for (int i = 0; i < 4; i++) sendByte(8'h00);
    gap(1);
    sendByte(8'h4D); sendByte(8'hEA); sendByte(8'h4D); sendByte(8'hEA);
    sendByte(8'h6D); sendByte(8'h54);
    for (int i = 0; i < 4; i++) sendByte(8'h00);
    gap(1);

    // R7: back to back patterns, each strobes once
    phase = "R7";
    sendReg(8'h37); sendMem(); sendReg(8'h3B); sendMem();
    gap(3);

    // R8: selectors outside the implemented range
    phase = "R8";
    sendReg(8'h2F); gap(1);
    sendReg(8'h40); gap(1);
    sendReg(8'hFF); gap(1);
    sendReg(8'h00); gap(1);
    checkEq("R8", "holdData0 unchanged", 32'(holdData0), 32'(regFile[11]));

    // R9: gaps carrying pattern-like data with byteValid low
    phase = "R9";
    sendByte(8'h53); gapData(8'h53); sendByte(8'h70); gapData(8'h00);
    sendByte(8'hEE); gapData(8'h4D); sendByte(8'h3C); gapData(8'h01);
    sendByte(8'h00); gapData(8'hFF); sendByte(8'h00); sendByte(8'h00);
    gapData(8'h53); sendByte(8'h00);
    gap(1);
    checkEq("R9", "holdData0 via gaps", 32'(holdData0), 32'(regFile[12]));
    for (int i = 0; i < 8; i++) gapData(memPat[i]);

    // mixed stream
    phase = "R7";
    for (int k = 0; k < 400; k++) begin
      int sel;
      sel = $urandom_range(0, 11);
      if (sel == 0)      sendReg(8'(8'h2E + $urandom_range(0, 20)));
      else if (sel == 1) sendMem();
      else if (sel < 4)  gap(1);
      else begin
        case ($urandom_range(0, 7))
          0: sendByte(8'h53); 1: sendByte(8'h70); 2: sendByte(8'hEE);
          3: sendByte(8'h00); 4: sendByte(8'h4D); 5: sendByte(8'hEA);
          6: sendByte(8'h6D); default: sendByte(8'($urandom));
        endcase
      end
    end
    gap(3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule